// File: doc/BRIEF.md
# Bus-Master DMA Register Bank

This block is the software-facing register file that sits in front of a scatter-gather DMA engine. It holds a command byte, a status byte and a 32-bit pointer to the start of the descriptor table in memory. Software reaches these registers through a byte-addressed port that carries 1-, 2- or 4-byte accesses. The bank turns changes of the command start bit into launch and stop signals for the engine. It keeps the busy, error and interrupt flags, and it forwards the device interrupt line to the host.

The eight-byte register window is split into two words. The low word carries the command byte in byte 0 and the status byte in byte 2. Bytes 1 and 3 are reserved and read as zero. The high word (address bit 2 set) is the descriptor table pointer. Reads are combinational: the addressed word is shifted right by eight times the byte offset and then masked to the access width. A write changes only the byte lanes it covers.

When software raises the start bit, the engine's fetch pointer is reloaded from the table pointer. If the engine is idle it is also marked busy and kicked. When software clears the start bit the engine is only notified. A transfer in flight always runs until the engine reports done or error.

Top module: `dma_busmaster_regs`

## Requirements
- R1: A command write stores only bit 0 (start) and bit 3 (direction); every other command bit reads back as zero. Writes that cover only the reserved bytes 1 and 3 change nothing.
- R2: A command write whose start bit equals the stored start bit does not reload the fetch pointer, does not pulse `eng_kick` and does not change busy.
- R3: A 0-to-1 change of the start bit loads `eng_ptr` from the table pointer on the write edge. If busy was clear, it also sets busy (status bit 0) and raises `eng_kick` for exactly one cycle. If busy was already set, there is no kick.
- R4: A 1-to-0 change of the start bit pulses `eng_stop` for one cycle and leaves busy set.
- R5: `eng_done` clears busy on the next edge.
- R6: `eng_err` sets the error flag (status bit 1) and clears busy on the next edge.
- R7: A write to the table pointer changes only the addressed byte lanes (byte offset = address bits 1:0; size code 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes). Bits 1:0 of the pointer always hold zero.
- R8: `reg_rdata` equals the addressed word shifted right by 8 x offset and masked to the access width. The low word is {8'h00, status, 8'h00, command}.
- R9: A rising edge of `dev_irq` sets the interrupt flag (status bit 2). `host_irq` follows the level of `dev_irq`, and a falling `dev_irq` leaves the status unchanged.
- R10: Status bits 2 and 1 clear when a 1 is written to them and bit 0 is read-only. When an engine or device event sets a flag in the same cycle as software clears it, the set wins.
- R11: Synchronous reset clears command, status, table pointer, fetch pointer, busy and both pulses.
- R12: `eng_dir` presents the stored command bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Byte address: bit 2 selects the pointer word, bits 1:0 are the byte offset |
| reg_size | input | 2 | Access size code: 0 = byte, 1 = half, 2 or 3 = word |
| reg_wdata | input | 32 | Write value, right-aligned |
| reg_rdata | output | 32 | Read value, right-aligned and masked |
| dev_irq | input | 1 | Interrupt level from the device |
| host_irq | output | 1 | Interrupt level forwarded to the host |
| eng_kick | output | 1 | One-cycle launch pulse to the engine |
| eng_stop | output | 1 | One-cycle advisory stop pulse |
| eng_active | output | 1 | Busy flag (status bit 0) |
| eng_dir | output | 1 | Transfer direction from command bit 3 |
| eng_ptr | output | 32 | Fetch pointer loaded on start |
| eng_done | input | 1 | Engine finished the transfer |
| eng_err | input | 1 | Engine hit an error |

## Verification
The bench first rewrites the start bit with its current value and checks that neither a kick nor a pointer reload follows. A bank that reacts to the level instead of the edge would restart the engine on every command write. It then clears the start bit and raises it again while a transfer is still busy. A design that aborts on stop would drop busy, and one that kicks on every rising edge would launch twice. Partial-width pointer writes at each offset show whether neighbouring lanes are clobbered or the two low bits leak through. Finally, a device interrupt edge arrives in the same cycle as a software clear of that flag. If clear wins there, the interrupt is lost.

// File: rtl/dmaregs_pkg.sv
package dmaregs_pkg;

    localparam int REG_W_DEF = 32;

    // byte lanes of the low word
    localparam int CMD_LANE  = 0;
    localparam int STAT_LANE = 2;

    localparam logic [7:0] CMD_KEEP_MASK = 8'h09;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2,
        ACC_WIDE = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic [3:0] rsvd_hi;
        logic       dir;
        logic [1:0] rsvd_mid;
        logic       start;
    } cmd_t;

    typedef struct packed {
        logic [4:0] rsvd;
        logic       irq;
        logic       err;
        logic       busy;
    } stat_t;

endpackage

// File: rtl/dmaregs_lanes.sv
module dmaregs_lanes
    import dmaregs_pkg::*;
#(
    parameter int REG_W = REG_W_DEF,
    localparam int LANES = REG_W / 8,
    localparam int OFF_W = $clog2(LANES),
    localparam int CNT_W = OFF_W + 2
) (
    input  logic [OFF_W-1:0] off,
    input  acc_size_e        size,
    input  logic [REG_W-1:0] wdata,
    output logic [LANES-1:0] lane_en,
    output logic [REG_W-1:0] wdata_sh,
    output logic [REG_W-1:0] rmask
);

    logic [CNT_W-1:0] nbytes;

    always_comb begin
        case (size)
            ACC_BYTE: nbytes = CNT_W'(1);
            ACC_HALF: nbytes = CNT_W'(2);
            default:  nbytes = CNT_W'(LANES);
        endcase
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_en[i] = (CNT_W'(i) >= CNT_W'(off)) &&
                            (CNT_W'(i) <  CNT_W'(off) + nbytes);
    end

    assign wdata_sh = wdata << {off, 3'b000};
    assign rmask    = (nbytes >= CNT_W'(LANES)) ? '1 :
                      ((REG_W'(1) << {nbytes, 3'b000}) - REG_W'(1));

endmodule

// File: rtl/dmaregs_base.sv
module dmaregs_base
    import dmaregs_pkg::*;
#(
    parameter int REG_W = REG_W_DEF,
    localparam int LANES = REG_W / 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] we,
    input  logic [REG_W-1:0] wdata_sh,
    output logic [REG_W-1:0] base_q
);

    logic [7:0] lane_q [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [7:0] nxt;
        if (i == 0) begin : g_align
            // pointer is 4-byte aligned: low two bits never store
            assign nxt = {wdata_sh[7:2], 2'b00};
        end else begin : g_plain
            assign nxt = wdata_sh[8*i +: 8];
        end

        always_ff @(posedge clk) begin
            if (rst)
                lane_q[i] <= '0;
            else if (we[i])
                lane_q[i] <= nxt;
        end

        assign base_q[8*i +: 8] = lane_q[i];
    end

endmodule

// File: rtl/dmaregs_cmd.sv
module dmaregs_cmd
    import dmaregs_pkg::*;
#(
    parameter int REG_W = REG_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_we,
    input  logic [7:0]       cmd_wdata,
    input  logic [REG_W-1:0] base_in,
    input  logic             eng_done,
    input  logic             eng_err,
    output cmd_t             cmd_q,
    output logic             busy,
    output logic             kick,
    output logic             stop,
    output logic [REG_W-1:0] fetch_ptr
);

    cmd_t wr_val;
    logic start_rise;
    logic start_fall;

    assign wr_val     = cmd_t'(cmd_wdata & CMD_KEEP_MASK);
    assign start_rise = cmd_we &&  wr_val.start && !cmd_q.start;
    assign start_fall = cmd_we && !wr_val.start &&  cmd_q.start;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q     <= '0;
            busy      <= 1'b0;
            kick      <= 1'b0;
            stop      <= 1'b0;
            fetch_ptr <= '0;
        end else begin
            kick <= start_rise && !busy;
            stop <= start_fall;
            if (cmd_we)
                cmd_q <= wr_val;
            if (start_rise)
                fetch_ptr <= base_in;
            if (start_rise && !busy)
                busy <= 1'b1;
            else if (eng_done || eng_err)
                busy <= 1'b0;
        end
    end

endmodule

// File: rtl/dmaregs_status.sv
module dmaregs_status
    import dmaregs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       dev_irq,
    input  logic       eng_err,
    input  logic       st_we,
    input  logic [7:0] st_wdata,
    output logic       err_q,
    output logic       irq_q,
    output logic       irq_out
);

    stat_t clr;
    logic  irq_seen;
    logic  irq_rise;

    assign clr      = stat_t'(st_wdata);
    assign irq_rise = dev_irq && !irq_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q    <= 1'b0;
            irq_q    <= 1'b0;
            irq_seen <= 1'b0;
        end else begin
            irq_seen <= dev_irq;
            if (eng_err)
                err_q <= 1'b1;
            else if (st_we && clr.err)
                err_q <= 1'b0;
            if (irq_rise)
                irq_q <= 1'b1;
            else if (st_we && clr.irq)
                irq_q <= 1'b0;
        end
    end

    assign irq_out = dev_irq;

endmodule

// File: rtl/dma_busmaster_regs.sv
module dma_busmaster_regs
    import dmaregs_pkg::*;
#(
    parameter int REG_W = REG_W_DEF,
    localparam int LANES = REG_W / 8,
    localparam int OFF_W = $clog2(LANES),
    localparam int ADDR_W = OFF_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [1:0]        reg_size,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              dev_irq,
    output logic              host_irq,
    output logic              eng_kick,
    output logic              eng_stop,
    output logic              eng_active,
    output logic              eng_dir,
    output logic [REG_W-1:0]  eng_ptr,
    input  logic              eng_done,
    input  logic              eng_err
);

    logic             sel_hi;
    logic [OFF_W-1:0] off;
    logic [LANES-1:0] lane_en;
    logic [REG_W-1:0] wdata_sh;
    logic [REG_W-1:0] rmask;
    logic [REG_W-1:0] base_q;
    logic [REG_W-1:0] lo_word;
    logic [LANES-1:0] base_we;
    logic             cmd_we;
    logic             st_we;
    logic             err_q;
    logic             irq_q;
    cmd_t             cmd_q;
    stat_t            stat_q;

    assign sel_hi = reg_addr[OFF_W];
    assign off    = reg_addr[OFF_W-1:0];

    dmaregs_lanes #(.REG_W(REG_W)) u_lanes (
        .off      (off),
        .size     (acc_size_e'(reg_size)),
        .wdata    (reg_wdata),
        .lane_en  (lane_en),
        .wdata_sh (wdata_sh),
        .rmask    (rmask)
    );

    assign base_we = {LANES{reg_wr && sel_hi}} & lane_en;
    assign cmd_we  = reg_wr && !sel_hi && lane_en[CMD_LANE];
    assign st_we   = reg_wr && !sel_hi && lane_en[STAT_LANE];

    dmaregs_base #(.REG_W(REG_W)) u_base (
        .clk      (clk),
        .rst      (rst),
        .we       (base_we),
        .wdata_sh (wdata_sh),
        .base_q   (base_q)
    );

    dmaregs_cmd #(.REG_W(REG_W)) u_cmd (
        .clk       (clk),
        .rst       (rst),
        .cmd_we    (cmd_we),
        .cmd_wdata (wdata_sh[8*CMD_LANE +: 8]),
        .base_in   (base_q),
        .eng_done  (eng_done),
        .eng_err   (eng_err),
        .cmd_q     (cmd_q),
        .busy      (eng_active),
        .kick      (eng_kick),
        .stop      (eng_stop),
        .fetch_ptr (eng_ptr)
    );

    dmaregs_status u_status (
        .clk      (clk),
        .rst      (rst),
        .dev_irq  (dev_irq),
        .eng_err  (eng_err),
        .st_we    (st_we),
        .st_wdata (wdata_sh[8*STAT_LANE +: 8]),
        .err_q    (err_q),
        .irq_q    (irq_q),
        .irq_out  (host_irq)
    );

    always_comb begin
        stat_q      = '0;
        stat_q.busy = eng_active;
        stat_q.err  = err_q;
        stat_q.irq  = irq_q;
    end

    always_comb begin
        lo_word                      = '0;
        lo_word[8*CMD_LANE  +: 8]    = cmd_q;
        lo_word[8*STAT_LANE +: 8]    = stat_q;
    end

    assign eng_dir   = cmd_q.dir;
    assign reg_rdata = ((sel_hi ? base_q : lo_word) >> {off, 3'b000}) & rmask;

endmodule

// File: rtl/dmaregs_chk.sv
module dmaregs_chk #(
    parameter int REG_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             dev_irq,
    input logic             eng_kick,
    input logic             eng_stop,
    input logic             eng_active,
    input logic             eng_done,
    input logic             eng_err,
    input logic [7:0]       cmd_q,
    input logic [7:0]       stat_q,
    input logic [REG_W-1:0] base_q
);

    // R1: only start and direction bits are ever stored
    a_r1_cmd_bits: assert property (@(posedge clk) disable iff (rst)
        (cmd_q & 8'hF6) == 8'h00);

    // R3: a launch pulse always comes with busy set
    a_r3_kick_busy: assert property (@(posedge clk) disable iff (rst)
        eng_kick |-> eng_active);

    // R2: launch only follows a real 0-to-1 change of start
    a_r2_kick_on_edge: assert property (@(posedge clk) disable iff (rst)
        eng_kick |-> (cmd_q[0] && !$past(cmd_q[0])));

    // R4: stopping leaves busy untouched
    a_r4_stop_keeps_busy: assert property (@(posedge clk) disable iff (rst)
        (eng_stop && $past(!eng_done && !eng_err)) |-> (eng_active == $past(eng_active)));

    // R5: completion drops busy unless a new launch happened
    a_r5_done_clears: assert property (@(posedge clk) disable iff (rst)
        (eng_done || eng_err) |=> (!eng_active || eng_kick));

    // R6: engine error is recorded
    a_r6_err_sets: assert property (@(posedge clk) disable iff (rst)
        eng_err |=> stat_q[1]);

    // R7: pointer stays 4-byte aligned
    a_r7_aligned: assert property (@(posedge clk) disable iff (rst)
        base_q[1:0] == 2'b00);

    // R9: device interrupt edge is latched
    a_r9_irq_latch: assert property (@(posedge clk) disable iff (rst)
        (dev_irq && !$past(dev_irq)) |=> stat_q[2]);

endmodule

bind dma_busmaster_regs dmaregs_chk #(.REG_W(REG_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .dev_irq    (dev_irq),
    .eng_kick   (eng_kick),
    .eng_stop   (eng_stop),
    .eng_active (eng_active),
    .eng_done   (eng_done),
    .eng_err    (eng_err),
    .cmd_q      (cmd_q),
    .stat_q     (stat_q),
    .base_q     (base_q)
);

// File: tb/dma_busmaster_regs_tb.sv
module dma_busmaster_regs_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [1:0]  reg_size = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dev_irq = 1'b0;
    logic        host_irq;
    logic        eng_kick;
    logic        eng_stop;
    logic        eng_active;
    logic        eng_dir;
    logic [31:0] eng_ptr;
    logic        eng_done = 1'b0;
    logic        eng_err = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit reported = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_t;

    exp_t sb[$];
    exp_t mon_item;
    logic mon_en = 1'b0;

    always #2 clk = ~clk;

    dma_busmaster_regs u_dut (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_size   (reg_size),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .dev_irq    (dev_irq),
        .host_irq   (host_irq),
        .eng_kick   (eng_kick),
        .eng_stop   (eng_stop),
        .eng_active (eng_active),
        .eng_dir    (eng_dir),
        .eng_ptr    (eng_ptr),
        .eng_done   (eng_done),
        .eng_err    (eng_err)
    );

    // monitor: pops expected read values and compares
    always @(negedge clk) begin
        if (mon_en && sb.size() > 0) begin
            mon_item = sb.pop_front();
            n_cmp++;
            if (reg_rdata !== mon_item.exp) begin
                n_bad++;
                $display("FAIL %s: got %h expected %h", mon_item.tag, reg_rdata, mon_item.exp);
            end
        end
    end

    task automatic summary();
        if (!reported) begin
            reported = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_size = sz; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [1:0] sz,
                      input logic [31:0] exp, input string tag);
        @(posedge clk); #1;
        reg_addr = a; reg_size = sz;
        sb.push_back('{exp, tag});
        mon_en = 1'b1;
        @(posedge clk); #1;
        mon_en = 1'b0;
    endtask

    task automatic pulse_done();
        @(posedge clk); #1 eng_done = 1'b1;
        @(posedge clk); #1 eng_done = 1'b0;
    endtask

    task automatic pulse_err();
        @(posedge clk); #1 eng_err = 1'b1;
        @(posedge clk); #1 eng_err = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R11: reset state
        chk(eng_active, 0, "R11 busy after reset");
        chk(eng_kick, 0, "R11 kick after reset");
        chk(eng_ptr, 0, "R11 ptr after reset");
        rd(3'd0, 2'd0, 32'h0, "R11 cmd after reset");
        rd(3'd2, 2'd0, 32'h0, "R11 status after reset");
        rd(3'd4, 2'd2, 32'h0, "R11 base after reset");

        // R7: lane writes and alignment
        wr(3'd4, 2'd2, 32'h1234_5677);
        rd(3'd4, 2'd2, 32'h1234_5674, "R7 word write low bits forced");
        wr(3'd5, 2'd0, 32'h0000_00AB);
        rd(3'd4, 2'd2, 32'h1234_AB74, "R7 byte lane 1");
        wr(3'd6, 2'd1, 32'h0000_CDEF);
        rd(3'd4, 2'd2, 32'hCDEF_AB74, "R7 half at offset 2");
        wr(3'd4, 2'd0, 32'h0000_003F);
        rd(3'd4, 2'd2, 32'hCDEF_AB3C, "R7 byte lane 0 aligned");

        // R8: shifted, masked reads
        rd(3'd5, 2'd0, 32'h0000_00AB, "R8 byte read offset 1");
        rd(3'd6, 2'd1, 32'h0000_CDEF, "R8 half read offset 2");
        rd(3'd4, 2'd1, 32'h0000_AB3C, "R8 half read offset 0");

        // R1 R3 R12: launch from idle with masked command
        wr(3'd0, 2'd0, 32'h0000_00FF);
        chk(eng_kick, 1, "R3 kick on start rise");
        chk(eng_active, 1, "R3 busy on start rise");
        chk(eng_ptr, 32'hCDEF_AB3C, "R3 ptr loaded");
        chk(eng_dir, 1, "R12 dir set");
        @(posedge clk); #1;
        chk(eng_kick, 0, "R3 kick one cycle");
        rd(3'd0, 2'd0, 32'h0000_0009, "R1 cmd masked");
        rd(3'd2, 2'd0, 32'h0000_0001, "R3 status busy");

        // R2: same start value, no effect
        wr(3'd4, 2'd2, 32'h0000_1000);
        wr(3'd0, 2'd0, 32'h0000_000F);
        chk(eng_kick, 0, "R2 no kick");
        chk(eng_ptr, 32'hCDEF_AB3C, "R2 ptr not reloaded");
        chk(eng_active, 1, "R2 busy unchanged");

        // R4: stop does not abort
        wr(3'd0, 2'd0, 32'h0000_0008);
        chk(eng_stop, 1, "R4 stop pulse");
        chk(eng_active, 1, "R4 busy kept");
        repeat (3) @(posedge clk);
        #1 chk(eng_active, 1, "R4 busy still kept");

        // R3: restart while busy reloads pointer, no kick
        wr(3'd0, 2'd0, 32'h0000_0001);
        chk(eng_kick, 0, "R3 no kick while busy");
        chk(eng_ptr, 32'h0000_1000, "R3 ptr reloaded while busy");
        chk(eng_dir, 0, "R12 dir clear");

        // R5: done clears busy
        pulse_done();
        chk(eng_active, 0, "R5 busy cleared by done");
        rd(3'd2, 2'd0, 32'h0, "R5 status idle");

        // R6: error
        wr(3'd0, 2'd0, 32'h0);
        wr(3'd0, 2'd0, 32'h1);
        chk(eng_kick, 1, "R3 relaunch kick");
        pulse_err();
        chk(eng_active, 0, "R6 busy cleared by error");
        rd(3'd2, 2'd0, 32'h0000_0002, "R6 error flag");

        // R9: interrupt latch and pass-through
        @(posedge clk); #1 dev_irq = 1'b1;
        #1 chk(host_irq, 1, "R9 irq forwarded high");
        rd(3'd2, 2'd0, 32'h0000_0006, "R9 irq flag set");
        dev_irq = 1'b0;
        #1 chk(host_irq, 0, "R9 irq forwarded low");
        rd(3'd2, 2'd0, 32'h0000_0006, "R9 fall leaves status");

        // R10: write-one-to-clear, busy read-only, set wins
        wr(3'd0, 2'd0, 32'h0);
        wr(3'd0, 2'd0, 32'h1);
        wr(3'd2, 2'd0, 32'h0000_0004);
        rd(3'd2, 2'd0, 32'h0000_0003, "R10 clear irq only");
        wr(3'd2, 2'd0, 32'h0000_0003);
        rd(3'd2, 2'd0, 32'h0000_0001, "R10 busy read-only");
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = 3'd2; reg_size = 2'd0; reg_wdata = 32'h4;
        dev_irq = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
        dev_irq = 1'b0;
        rd(3'd2, 2'd0, 32'h0000_0005, "R10 set beats clear");

        // R8 R1: low word view, reserved byte ignored
        rd(3'd0, 2'd2, 32'h0005_0001, "R8 low word read");
        rd(3'd2, 2'd1, 32'h0000_0005, "R8 half read of status");
        wr(3'd1, 2'd0, 32'h0000_00FF);
        chk(eng_kick, 0, "R1 reserved write no kick");
        rd(3'd0, 2'd2, 32'h0005_0001, "R1 reserved write ignored");

        // R11: reset while busy
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        chk(eng_active, 0, "R11 busy cancelled");
        chk(eng_ptr, 0, "R11 ptr cleared");
        rd(3'd0, 2'd2, 32'h0, "R11 low word cleared");
        rd(3'd4, 2'd2, 32'h0, "R11 base cleared");

        repeat (2) @(posedge clk);
        summary();
        $finish;
    end

endmodule